// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file for board housekeeping. A host reaches it over a plain 32-bit read/write bus with a combinational read path. It holds the state behind an 8-LED bar and an 8-character ASCII display. The display can be loaded in one write, which spells the 32-bit data as eight uppercase hex digits, or one character at a time. The block also holds a break/reset byte and a general-purpose output byte. A magic-value write to a trigger register requests a system reset. A set of registers bit-bangs a two-wire serial bus: the clock and data lines are driven from an output register, gated by an output-enable register, and the data line is read back live.

Only the low 20 address bits are decoded, so the register window repeats through the rest of the address space. The byte order of the configuration shows only in the value of the status register.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, LEDs read 0x00, break/reset reads 0x0A, GP output is 0x00, output-enable is 0, the two-wire output register is 0x3 (both lines high), select reads 1, and all eight display characters are 0x20 (space).
- R2: Only address bits 19:0 take part in decoding: an access at 0xFFF00408 reaches the LED register exactly as 0x408 does.
- R3: Offsets 0x200 (switches) and 0x210 (jumpers) read zero, and writes to them have no effect. Any offset outside the map reads zero, and writing to it changes no output or register.
- R4: The status register at 0x208 reads 0x12 when the parameter BIG_ENDIAN is 1 and 0x10 when it is 0 (default 0).
- R5: The LED (0x408), break/reset (0x508) and GP output (0xA00) registers keep the low 8 bits of a write and read back zero-extended. ledBar and gpOut show the stored values.
- R6: A write to 0x410 sets display character i (dispChars[8i+7:8i]) to the uppercase ASCII hex digit of data nibble [31-4i:28-4i], so character 0 shows the most significant nibble.
- R7: A write to offset 0x418 + 8*i (i = 0..7) stores data[7:0] as character i. Offsets inside that range that are not a multiple of 8 away from 0x418 are unmapped.
- R8: A write of exactly 0x00000042 to 0x500 makes resetReq high for the single clock cycle that follows the write edge. Any other value written there leaves resetReq low. 0x500 reads zero.
- R9: The output-enable register (0xB08) keeps 2 bits and drives i2cOe. The select register (0xB18) keeps 1 bit. The output register (0xB10) keeps 2 bits, with bit 1 driving sclOut and bit 0 driving sdaOut. All three read back their stored bits.
- R10: Reading 0xB00 returns 0x2 in bits 31:1 and the live sdaIn level in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Bus byte address |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| sdaIn | input | 1 | Live level of the serial data line |
| ledBar | output | 8 | LED bar state |
| dispChars | output | 64 | Display characters, character i in bits 8i+7:8i |
| resetReq | output | 1 | One-cycle system reset request |
| gpOut | output | 8 | General-purpose output byte |
| sclOut | output | 1 | Serial clock line drive value |
| sdaOut | output | 1 | Serial data line drive value |
| i2cOe | output | 2 | Line output enables |

## Verification
A wrong decode or a corrupted register shows on the very next read of that offset, and for most registers also on the dedicated output pin in the cycle after the write. A fault in the hex conversion or in the character index shows as a wrong byte in dispChars one cycle after the write. A fault in the trigger logic shows as a missing, extra or misplaced resetReq pulse at the cycle right after the write edge. Random writes are compared against a model of the registers after every access, so a fault appears within a few accesses of the stimulus that exposes it.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  localparam int NUM_CHARS  = 8;
  localparam int CHAR_IDX_W = $clog2(NUM_CHARS);

  localparam logic [19:0] OFF_SWITCH   = 20'h00200;
  localparam logic [19:0] OFF_STATUS   = 20'h00208;
  localparam logic [19:0] OFF_JUMPER   = 20'h00210;
  localparam logic [19:0] OFF_LED      = 20'h00408;
  localparam logic [19:0] OFF_WORD     = 20'h00410;
  localparam logic [19:0] OFF_CHAR0    = 20'h00418;
  localparam logic [19:0] OFF_CHARLAST = OFF_CHAR0 + 20'((NUM_CHARS - 1) * 8);
  localparam logic [19:0] OFF_SOFTRST  = 20'h00500;
  localparam logic [19:0] OFF_BRK      = 20'h00508;
  localparam logic [19:0] OFF_GP       = 20'h00a00;
  localparam logic [19:0] OFF_LNIN     = 20'h00b00;
  localparam logic [19:0] OFF_LNOE     = 20'h00b08;
  localparam logic [19:0] OFF_LNOUT    = 20'h00b10;
  localparam logic [19:0] OFF_LNSEL    = 20'h00b18;

  localparam logic [31:0] RESET_MAGIC = 32'h42;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STATUS, RD_LED, RD_BRK, RD_GP,
    RD_LNIN, RD_LNOE, RD_LNOUT, RD_LNSEL
  } rdSel_e;

  typedef struct packed {
    logic                  ledWr;
    logic                  wordWr;
    logic                  charWr;
    logic [CHAR_IDX_W-1:0] charIdx;
    logic                  softRst;
    logic                  brkWr;
    logic                  gpWr;
    logic                  oeWr;
    logic                  outWr;
    logic                  selWr;
    rdSel_e                rdSel;
  } strobe_t;

  function automatic logic [7:0] hexAscii(input logic [3:0] nib);
    return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
  endfunction
endpackage

// File: rtl/board_ctrl_ctrl.sv
module board_ctrl_ctrl
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEC_W  = 20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  logic [19:0] offset;
  logic [19:0] charOff;

  always_comb begin
    offset = '0;
    offset[DEC_W-1:0] = busAddr[DEC_W-1:0];
  end

  assign charOff = offset - OFF_CHAR0;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_ZERO;
    case (offset)
      OFF_STATUS:  strb.rdSel = RD_STATUS;
      OFF_LED:     begin strb.rdSel = RD_LED;   strb.ledWr = busWrite; end
      OFF_WORD:    strb.wordWr = busWrite;
      OFF_SOFTRST: strb.softRst = busWrite && (busWdata == DATA_W'(RESET_MAGIC));
      OFF_BRK:     begin strb.rdSel = RD_BRK;   strb.brkWr = busWrite; end
      OFF_GP:      begin strb.rdSel = RD_GP;    strb.gpWr  = busWrite; end
      OFF_LNIN:    strb.rdSel = RD_LNIN;
      OFF_LNOE:    begin strb.rdSel = RD_LNOE;  strb.oeWr  = busWrite; end
      OFF_LNOUT:   begin strb.rdSel = RD_LNOUT; strb.outWr = busWrite; end
      OFF_LNSEL:   begin strb.rdSel = RD_LNSEL; strb.selWr = busWrite; end
      default: begin
        if (offset >= OFF_CHAR0 && offset <= OFF_CHARLAST && offset[2:0] == 3'b000) begin
          strb.charWr  = busWrite;
          strb.charIdx = charOff[3 +: CHAR_IDX_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
#(
  parameter int  DATA_W     = 32,
  parameter bit  BIG_ENDIAN = 1'b0,
  localparam int DISP_W     = NUM_CHARS * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [7:0]        ledBar,
  output logic [DISP_W-1:0] dispChars,
  output logic              resetReq,
  output logic [7:0]        gpOut,
  output logic              sclOut,
  output logic              sdaOut,
  output logic [1:0]        i2cOe
);
  localparam logic [7:0]  BRK_RESET   = 8'h0a;
  localparam logic [7:0]  STATUS_VAL  = BIG_ENDIAN ? 8'h12 : 8'h10;
  localparam logic [DATA_W-1:0] LNIN_BASE = DATA_W'(2);

  logic [7:0] brkReg;
  logic [1:0] lineOut;
  logic       lineSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledBar   <= '0;
      brkReg   <= BRK_RESET;
      gpOut    <= '0;
      i2cOe    <= '0;
      lineOut  <= 2'b11;
      lineSel  <= 1'b1;
      resetReq <= 1'b0;
    end else begin
      resetReq <= strb.softRst;
      if (strb.ledWr) ledBar  <= busWdata[7:0];
      if (strb.brkWr) brkReg  <= busWdata[7:0];
      if (strb.gpWr)  gpOut   <= busWdata[7:0];
      if (strb.oeWr)  i2cOe   <= busWdata[1:0];
      if (strb.outWr) lineOut <= busWdata[1:0];
      if (strb.selWr) lineSel <= busWdata[0];
    end
  end

  assign sclOut = lineOut[1];
  assign sdaOut = lineOut[0];

  for (genvar g = 0; g < NUM_CHARS; g++) begin : gChar
    always_ff @(posedge clk) begin
      if (!rstN)
        dispChars[8*g +: 8] <= 8'h20;
      else if (strb.wordWr)
        dispChars[8*g +: 8] <= hexAscii(busWdata[DATA_W-1-4*g -: 4]);
      else if (strb.charWr && strb.charIdx == CHAR_IDX_W'(g))
        dispChars[8*g +: 8] <= busWdata[7:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      RD_STATUS: busRdata[7:0] = STATUS_VAL;
      RD_LED:    busRdata[7:0] = ledBar;
      RD_BRK:    busRdata[7:0] = brkReg;
      RD_GP:     busRdata[7:0] = gpOut;
      RD_LNIN:   busRdata = {LNIN_BASE[DATA_W-1:1], sdaIn};
      RD_LNOE:   busRdata[1:0] = i2cOe;
      RD_LNOUT:  busRdata[1:0] = lineOut;
      RD_LNSEL:  busRdata[0] = lineSel;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEC_W      = 20,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sdaIn,
  output logic [7:0]        ledBar,
  output logic [63:0]       dispChars,
  output logic              resetReq,
  output logic [7:0]        gpOut,
  output logic              sclOut,
  output logic              sdaOut,
  output logic [1:0]        i2cOe
);
  strobe_t strb;

  board_ctrl_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_W(DEC_W)) u_ctrl (
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .strb     (strb)
  );

  board_ctrl_datapath #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .sdaIn     (sdaIn),
    .busRdata  (busRdata),
    .ledBar    (ledBar),
    .dispChars (dispChars),
    .resetReq  (resetReq),
    .gpOut     (gpOut),
    .sclOut    (sclOut),
    .sdaOut    (sdaOut),
    .i2cOe     (i2cOe)
  );
endmodule

// File: rtl/board_ctrl_chk.sv
module board_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] busAddr,
  input logic        busWrite,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        sdaIn,
  input logic [7:0]  ledBar,
  input logic [63:0] dispChars,
  input logic        resetReq,
  input logic [7:0]  gpOut,
  input logic        sclOut,
  input logic        sdaOut,
  input logic [1:0]  i2cOe
);
  logic [19:0] off;
  logic        dispTouch;
  assign off = busAddr[19:0];
  assign dispTouch = busWrite && (off >= 20'h410) && (off <= 20'h450);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busWrite && off == 20'h500 && busWdata == 32'h42));

  assert_led_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && off == 20'h408) |=> $stable(ledBar));

  assert_gp_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && off == 20'ha00) |=> $stable(gpOut));

  assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && off == 20'hb10) |=> ($stable(sclOut) && $stable(sdaOut)));

  assert_oe_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && off == 20'hb08) |=> $stable(i2cOe));

  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dispTouch |=> $stable(dispChars));

  assert_zero_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (off == 20'h200 || off == 20'h210 || off == 20'h500 || off == 20'h41c) |-> busRdata == 32'h0);

  assert_line_in_R10: assert property (@(posedge clk) disable iff (!rstN)
    (off == 20'hb00) |-> (busRdata == {31'h1, sdaIn}));
endmodule

bind board_ctrl_regs board_ctrl_chk u_chk (.*);

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sdaIn = 1'b1;
  logic [7:0]  ledBar;
  logic [63:0] dispChars;
  logic        resetReq;
  logic [7:0]  gpOut;
  logic        sclOut;
  logic        sdaOut;
  logic [1:0]  i2cOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  mLed, mBrk, mGp;
  logic [1:0]  mOe, mOut;
  logic        mSel;
  logic [63:0] mDisp;

  always #2.5 clk = ~clk;

  board_ctrl_regs dut (.*);

  function automatic logic [7:0] hexChar(input logic [3:0] n);
    return (n < 10) ? 8'(8'd48 + n) : 8'(8'd55 + n);
  endfunction

  function automatic logic [63:0] wordDisp(input logic [31:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = hexChar(v[31-4*i -: 4]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrite = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    check({tag, " R5 led pin"}, ledBar, mLed);
    check({tag, " R5 gp pin"}, gpOut, mGp);
    check({tag, " R9 scl/sda"}, {sclOut, sdaOut}, mOut);
    check({tag, " R9 oe pin"}, i2cOe, mOe);
    check({tag, " R6 R7 display"}, dispChars, mDisp);
    rd(32'h508, v); check({tag, " R5 brk read"}, v, {24'h0, mBrk});
    rd(32'hb18, v); check({tag, " R9 sel read"}, v, {31'h0, mSel});
    rd(32'hb10, v); check({tag, " R9 out read"}, v, {30'h0, mOut});
  endtask

  initial begin
    logic [31:0] v, d, a;
    int kind;
    v = $urandom(32'd20240601);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mLed = 8'h00; mBrk = 8'h0a; mGp = 8'h00; mOe = 2'b00; mOut = 2'b11; mSel = 1'b1;
    mDisp = {8{8'h20}};
    // R1 reset state
    check("R1 resetReq", resetReq, 0);
    checkAll("R1");
    rd(32'h408, v); check("R1 led read", v, 0);
    rd(32'hb08, v); check("R1 oe read", v, 0);
    // R4 status
    rd(32'h208, v); check("R4 status", v, 32'h10);
    // R3 switches/jumpers
    wr(32'h200, 32'hffffffff); wr(32'h210, 32'hffffffff);
    rd(32'h200, v); check("R3 switch", v, 0);
    rd(32'h210, v); check("R3 jumper", v, 0);
    // R5 masking and R2 aliasing
    wr(32'hfff00408, 32'h1234_56a5); mLed = 8'ha5;
    rd(32'h408, v); check("R2 alias led", v, 32'ha5);
    rd(32'h00100408, v); check("R2 alias read", v, 32'ha5);
    // R6 word load
    wr(32'h410, 32'h09af_3c7e); mDisp = wordDisp(32'h09af_3c7e);
    check("R6 hex word", dispChars, mDisp);
    // R7 per char, and in-between offset unmapped (R3)
    wr(32'h450, 32'h0000_0141); mDisp[63:56] = 8'h41;
    wr(32'h41c, 32'h0000_005a);
    check("R7 char7 and R3 gap", dispChars, mDisp);
    rd(32'h41c, v); check("R3 gap read", v, 0);
    // R3 unmapped write
    wr(32'h00c00, 32'hffff_ffff);
    checkAll("R3 unmapped");
    // R8 soft reset
    wr(32'h500, 32'h43);
    check("R8 non-magic", resetReq, 0);
    @(negedge clk); busAddr = 32'h500; busWdata = 32'h42; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
    check("R8 pulse", resetReq, 1);
    @(negedge clk); check("R8 pulse ends", resetReq, 0);
    wr(32'h500, 32'h142);
    check("R8 upper bits", resetReq, 0);
    rd(32'h500, v); check("R8 read zero", v, 0);
    // R10 line input
    sdaIn = 1'b0; rd(32'hb00, v); check("R10 sda low", v, 32'h2);
    sdaIn = 1'b1; rd(32'hb00, v); check("R10 sda high", v, 32'h3);
    // R9 masking
    wr(32'hb08, 32'hffff_fffe); mOe = 2'b10;
    wr(32'hb10, 32'hffff_fff1); mOut = 2'b01;
    wr(32'hb18, 32'hffff_fffe); mSel = 1'b0;
    checkAll("R9 directed");
    // random
    for (int it = 0; it < 300; it++) begin
      kind = int'($urandom_range(0, 8));
      d = $urandom();
      case (kind)
        0: begin a = 32'h408; mLed = d[7:0]; end
        1: begin a = 32'h508; mBrk = d[7:0]; end
        2: begin a = 32'ha00; mGp = d[7:0]; end
        3: begin a = 32'h410; mDisp = wordDisp(d); end
        4: begin
          int idx = int'($urandom_range(0, 7));
          a = 32'h418 + 32'(idx * 8); mDisp[8*idx +: 8] = d[7:0];
        end
        5: begin a = 32'hb08; mOe = d[1:0]; end
        6: begin a = 32'hb10; mOut = d[1:0]; end
        7: begin a = 32'hb18; mSel = d[0]; end
        default: a = 32'h604;
      endcase
      a[31:20] = 12'($urandom());
      wr(a, d);
      check("R8 random no pulse", resetReq, 0);
      checkAll("random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule